// File: doc/BRIEF.md
# Debug Shadow Scan Chain

This block gives a debug host serial access to the state of a small processor. Six shadow registers sit in one serial path clocked by the SPI clock. They hold copies of four 8-bit general registers, the 8-bit program counter and the 16-bit instruction register. An 8-bit control register sits at the head of that path. Every rising SPI clock edge moves the whole path one bit. The host shifts a new image in on `mosi` and reads the old image out on `miso` in the same transfer.

A falling edge of the processor clock requests a snapshot. The request crosses into the SPI clock domain, and a few SPI clocks later it turns one rising SPI edge into a parallel capture. On that edge each shadow register takes its live processor register, and the control register keeps its own contents. The control register's bits leave the block as a bypass request, a squelch request and four trigger bits. The block also computes the instruction-register load enable from the bypass and squelch bits.

Top module: `dbg_scan_chain`

## Requirements
- R1: While `rst_n` is low, every shadow register and the control register read zero, `miso` is 0, `bypass_req`, `squelch_req` and `trig` are 0, and `ir_load_en` is 1.
- R2: On a rising `spi_clk` edge with no capture, the chain `{ctrl, r0, r1, r2, r3, pc, ir}` (64 bits, `ctrl` most significant) shifts up by one bit. `mosi` enters bit 0 of the instruction-register shadow, and the MSB of each register passes into the LSB of the next register toward the control register.
- R3: With `spi_clk` idle low, a falling `cpu_clk` edge makes the third following rising `spi_clk` edge a capture instead of a shift. The first two of those edges shift normally.
- R4: On a capture edge, each shadow register loads its processor value (`r0` = `cpu_gpr[7:0]` up to `r3` = `cpu_gpr[31:24]`, `pc`, `ir`), and the control register keeps its value.
- R5: After a capture, the host samples `miso` before each of the next 64 rising edges. The bits arrive as the control register first, then `r0`, `r1`, `r2`, `r3`, `pc` and `ir`, each register MSB first.
- R6: Control bit 1 drives `bypass_req`, control bit 2 drives `squelch_req`, and control bits 7:4 drive `trig[3:0]`.
- R7: `ir_load_en` is high exactly when `bypass_req` and `squelch_req` are equal.
- R8: SPI clocks with no preceding `cpu_clk` falling edge only shift. A change of the processor values has no effect on the chain.
- R9: Driving `rst_n` low clears the chain at once, without any clock, and drops a capture request that is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| spi_clk | input | 1 | Serial clock; shifts the chain on its rising edge |
| cpu_clk | input | 1 | Processor clock; its falling edge requests a snapshot |
| rst_n | input | 1 | Asynchronous reset, active low |
| mosi | input | 1 | Serial data into the instruction-register shadow |
| cpu_gpr | input | 32 | Live general registers, r0 in the low byte |
| cpu_pc | input | 8 | Live program counter |
| cpu_ir | input | 16 | Live instruction register |
| miso | output | 1 | Serial data out, control register MSB |
| ctrl | output | 8 | Control register contents |
| sh_gpr | output | 32 | General register shadows, r0 in the low byte |
| sh_pc | output | 8 | Program counter shadow |
| sh_ir | output | 16 | Instruction register shadow |
| bypass_req | output | 1 | Bypass request from the control register |
| squelch_req | output | 1 | Squelch request from the control register |
| trig | output | 4 | Trigger bits from the control register |
| ir_load_en | output | 1 | Instruction register load enable |

## Verification
The checks assume that `cpu_clk` falls only while `spi_clk` is low. They also assume that two snapshot requests are at least three SPI clocks apart, because two toggles inside the synchronizer window would cancel, and that the processor values stay steady from a request until its capture edge. The stimulus keeps to these rules. Each processor pulse comes while the SPI clock is idle, and each random burst runs at least three SPI clocks after its pulse. The processor values change only at the start of a burst, while no capture is pending.

// File: rtl/dbg_scan_pkg.sv
`timescale 1ns/1ps
package dbg_scan_pkg;
    // Control register layout: bit positions decoded by the processor side
    localparam int CTRL_W      = 8;
    localparam int BYPASS_BIT  = 1;
    localparam int SQUELCH_BIT = 2;
    localparam int TRIG_LSB    = 4;
    localparam int TRIG_W      = 4;

    // Processor-clock side of the snapshot request
    typedef struct packed {
        logic req;
    } cpu_side_t;
endpackage

// File: rtl/dbg_scan_seg.sv
`timescale 1ns/1ps
// One shadow register: parallel capture or MSB-first shift on each edge
module dbg_scan_seg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         ser_in,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] par_out,
    output logic         ser_out
);
    typedef struct packed {
        logic [W-1:0] data;
    } seg_t;

    seg_t seg_d, seg_q;

    always_comb begin
        seg_d = seg_q;
        if (load) begin
            seg_d.data = par_in;
        end else begin
            seg_d.data = {seg_q.data[W-2:0], ser_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q <= '0;
        end else begin
            seg_q <= seg_d;
        end
    end

    assign par_out = seg_q.data;
    assign ser_out = seg_q.data[W-1];
endmodule

// File: rtl/dbg_capture_sync.sv
`timescale 1ns/1ps
// Snapshot request: toggled by the processor clock falling edge, carried
// through a synchronizer on the SPI clock falling edge, acknowledged one
// SPI falling edge after it arrives. The pending window covers one rising edge.
module dbg_capture_sync
    import dbg_scan_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic cpu_clk,
    input  logic spi_clk,
    input  logic rst_n,
    output logic load
);
    typedef struct packed {
        logic [SYNC_N-1:0] sync;
        logic              ack;
    } spi_side_t;

    cpu_side_t cpu_d, cpu_q;
    spi_side_t spi_d, spi_q;

    always_comb begin
        cpu_d     = cpu_q;
        cpu_d.req = ~cpu_q.req;
    end

    always_ff @(negedge cpu_clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_q <= '0;
        end else begin
            cpu_q <= cpu_d;
        end
    end

    always_comb begin
        spi_d      = spi_q;
        spi_d.sync = {spi_q.sync[SYNC_N-2:0], cpu_q.req};
        spi_d.ack  = spi_q.sync[SYNC_N-1];
    end

    always_ff @(negedge spi_clk or negedge rst_n) begin
        if (!rst_n) begin
            spi_q <= '0;
        end else begin
            spi_q <= spi_d;
        end
    end

    assign load = spi_q.sync[SYNC_N-1] ^ spi_q.ack;
endmodule

// File: rtl/dbg_ctrl_decode.sv
`timescale 1ns/1ps
// Turns the control register bits into processor debug requests
module dbg_ctrl_decode
    import dbg_scan_pkg::*;
(
    input  logic              byp_bit,
    input  logic              sq_bit,
    input  logic [TRIG_W-1:0] trig_bits,
    output logic              bypass_req,
    output logic              squelch_req,
    output logic [TRIG_W-1:0] trig,
    output logic              ir_load_en
);
    always_comb begin
        bypass_req  = byp_bit;
        squelch_req = sq_bit;
        trig        = trig_bits;
        // load the instruction register when neither or both are requested
        ir_load_en  = ~(byp_bit ^ sq_bit);
    end
endmodule

// File: rtl/dbg_scan_chain.sv
`timescale 1ns/1ps
module dbg_scan_chain
    import dbg_scan_pkg::*;
#(
    parameter int DW      = 8,
    parameter int IW      = 16,
    parameter int NUM_GPR = 4
) (
    input  logic                  spi_clk,
    input  logic                  cpu_clk,
    input  logic                  rst_n,
    input  logic                  mosi,
    input  logic [NUM_GPR*DW-1:0] cpu_gpr,
    input  logic [DW-1:0]         cpu_pc,
    input  logic [IW-1:0]         cpu_ir,
    output logic                  miso,
    output logic [CTRL_W-1:0]     ctrl,
    output logic [NUM_GPR*DW-1:0] sh_gpr,
    output logic [DW-1:0]         sh_pc,
    output logic [IW-1:0]         sh_ir,
    output logic                  bypass_req,
    output logic                  squelch_req,
    output logic [TRIG_W-1:0]     trig,
    output logic                  ir_load_en
);
    logic               load;
    logic               ir_ser;
    logic               pc_ser;
    logic [NUM_GPR-1:0] gpr_ser;
    logic               ctrl_ser;

    dbg_capture_sync #(.SYNC_N(2)) u_cap (
        .cpu_clk (cpu_clk),
        .spi_clk (spi_clk),
        .rst_n   (rst_n),
        .load    (load)
    );

    // Tail of the chain: instruction register shadow fed from mosi
    dbg_scan_seg #(.W(IW)) u_ir (
        .clk     (spi_clk),
        .rst_n   (rst_n),
        .load    (load),
        .ser_in  (mosi),
        .par_in  (cpu_ir),
        .par_out (sh_ir),
        .ser_out (ir_ser)
    );

    dbg_scan_seg #(.W(DW)) u_pc (
        .clk     (spi_clk),
        .rst_n   (rst_n),
        .load    (load),
        .ser_in  (ir_ser),
        .par_in  (cpu_pc),
        .par_out (sh_pc),
        .ser_out (pc_ser)
    );

    // General registers: highest index nearest the program counter
    for (genvar g = 0; g < NUM_GPR; g++) begin : g_gpr
        logic sin;
        if (g == NUM_GPR - 1) begin : g_top
            assign sin = pc_ser;
        end else begin : g_mid
            assign sin = gpr_ser[g+1];
        end

        dbg_scan_seg #(.W(DW)) u_seg (
            .clk     (spi_clk),
            .rst_n   (rst_n),
            .load    (load),
            .ser_in  (sin),
            .par_in  (cpu_gpr[g*DW +: DW]),
            .par_out (sh_gpr[g*DW +: DW]),
            .ser_out (gpr_ser[g])
        );
    end

    // Head of the chain: control register reloads itself on capture
    dbg_scan_seg #(.W(CTRL_W)) u_ctrl (
        .clk     (spi_clk),
        .rst_n   (rst_n),
        .load    (load),
        .ser_in  (gpr_ser[0]),
        .par_in  (ctrl),
        .par_out (ctrl),
        .ser_out (ctrl_ser)
    );

    assign miso = ctrl_ser;

    dbg_ctrl_decode u_dec (
        .byp_bit     (ctrl[BYPASS_BIT]),
        .sq_bit      (ctrl[SQUELCH_BIT]),
        .trig_bits   (ctrl[TRIG_LSB +: TRIG_W]),
        .bypass_req  (bypass_req),
        .squelch_req (squelch_req),
        .trig        (trig),
        .ir_load_en  (ir_load_en)
    );
endmodule

// File: rtl/dbg_scan_chk.sv
`timescale 1ns/1ps
module dbg_scan_chk
    import dbg_scan_pkg::*;
#(
    parameter int DW      = 8,
    parameter int IW      = 16,
    parameter int NUM_GPR = 4
) (
    input logic                  spi_clk,
    input logic                  rst_n,
    input logic                  load,
    input logic                  mosi,
    input logic [CTRL_W-1:0]     ctrl,
    input logic [NUM_GPR*DW-1:0] sh_gpr,
    input logic [NUM_GPR*DW-1:0] cpu_gpr,
    input logic [DW-1:0]         sh_pc,
    input logic [DW-1:0]         cpu_pc,
    input logic [IW-1:0]         sh_ir,
    input logic [IW-1:0]         cpu_ir,
    input logic                  bypass_req,
    input logic [TRIG_W-1:0]     trig
);
    logic past_ok;

    always_ff @(posedge spi_clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    assert_shift_head_R2: assert property (@(posedge spi_clk) disable iff (!rst_n)
        past_ok && !$past(load) |-> ctrl == {$past(ctrl[CTRL_W-2:0]), $past(sh_gpr[DW-1])});

    assert_shift_entry_R2: assert property (@(posedge spi_clk) disable iff (!rst_n)
        past_ok && !$past(load) |-> sh_ir[0] == $past(mosi));

    assert_capture_R4: assert property (@(posedge spi_clk) disable iff (!rst_n)
        past_ok && $past(load) |-> (sh_gpr == $past(cpu_gpr)) && (sh_pc == $past(cpu_pc))
                                   && (sh_ir == $past(cpu_ir)) && (ctrl == $past(ctrl)));

    assert_ctrl_hold_R6: assert property (@(posedge spi_clk) disable iff (!rst_n)
        past_ok && $past(load) |-> $stable(bypass_req) && $stable(trig));

    assert_single_pulse_R3: assert property (@(posedge spi_clk) disable iff (!rst_n)
        load |=> !load);
endmodule

bind dbg_scan_chain dbg_scan_chk #(.DW(DW), .IW(IW), .NUM_GPR(NUM_GPR)) u_chk (
    .spi_clk    (spi_clk),
    .rst_n      (rst_n),
    .load       (load),
    .mosi       (mosi),
    .ctrl       (ctrl),
    .sh_gpr     (sh_gpr),
    .cpu_gpr    (cpu_gpr),
    .sh_pc      (sh_pc),
    .cpu_pc     (cpu_pc),
    .sh_ir      (sh_ir),
    .cpu_ir     (cpu_ir),
    .bypass_req (bypass_req),
    .trig       (trig)
);

// File: tb/test_dbg_scan_chain.sv
`timescale 1ns/1ps
module test_dbg_scan_chain;
    localparam int DW = 8;
    localparam int IW = 16;
    localparam int NG = 4;
    localparam int CW = 8 + NG*DW + DW + IW;

    logic           spi_clk = 1'b0;
    logic           cpu_clk = 1'b0;
    logic           rst_n   = 1'b0;
    logic           mosi    = 1'b0;
    logic [NG*DW-1:0] cpu_gpr = '0;
    logic [DW-1:0]  cpu_pc  = '0;
    logic [IW-1:0]  cpu_ir  = '0;

    logic           miso;
    logic [7:0]     ctrl;
    logic [NG*DW-1:0] sh_gpr;
    logic [DW-1:0]  sh_pc;
    logic [IW-1:0]  sh_ir;
    logic           bypass_req, squelch_req, ir_load_en;
    logic [3:0]     trig;

    int checks = 0;
    int fails  = 0;
    logic [CW-1:0] model = '0;
    int cap_cnt = 0;

    dbg_scan_chain i_dbg_scan_chain (
        .spi_clk(spi_clk), .cpu_clk(cpu_clk), .rst_n(rst_n), .mosi(mosi),
        .cpu_gpr(cpu_gpr), .cpu_pc(cpu_pc), .cpu_ir(cpu_ir),
        .miso(miso), .ctrl(ctrl), .sh_gpr(sh_gpr), .sh_pc(sh_pc), .sh_ir(sh_ir),
        .bypass_req(bypass_req), .squelch_req(squelch_req), .trig(trig),
        .ir_load_en(ir_load_en)
    );

    function automatic logic [CW-1:0] f_shift(logic [CW-1:0] c, logic b);
        return {c[CW-2:0], b};
    endfunction

    function automatic logic [CW-1:0] f_capture(logic [CW-1:0] c, logic [NG*DW-1:0] g,
                                                logic [DW-1:0] pc, logic [IW-1:0] ir);
        return {c[CW-1 -: 8], g[7:0], g[15:8], g[23:16], g[31:24], pc, ir};
    endfunction

    function automatic logic [CW+7:0] f_expect(logic [CW-1:0] c);
        logic [7:0] k;
        k = c[CW-1 -: 8];
        return {c, c[CW-1], k[1], k[2], k[7:4], ~(k[1] ^ k[2])};
    endfunction

    task automatic check(string req);
        logic [CW+7:0] got, exp;
        got = {ctrl, sh_gpr[7:0], sh_gpr[15:8], sh_gpr[23:16], sh_gpr[31:24], sh_pc, sh_ir,
               miso, bypass_req, squelch_req, trig, ir_load_en};
        exp = f_expect(model);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step(logic b, string tag);
        string t;
        t = tag;
        mosi = b;
        #1 spi_clk = 1'b1;
        if (cap_cnt == 3) begin
            model   = f_capture(model, cpu_gpr, cpu_pc, cpu_ir);
            cap_cnt = 0;
            t = "R3 R4";
        end else begin
            model = f_shift(model, b);
            if (cap_cnt > 0) begin
                cap_cnt++;
                t = "R3";
            end
        end
        #2 spi_clk = 1'b0;
        #1;
        check(t);
    endtask

    task automatic cpu_pulse();
        cpu_clk = 1'b1;
        #2 cpu_clk = 1'b0;
        #2;
        cap_cnt = 1;
    endtask

    task automatic load_word(logic [CW-1:0] w, string tag);
        for (int i = CW-1; i >= 0; i--) begin
            step(w[i], "R2");
        end
        check(tag);
    endtask

    initial begin
        logic [CW-1:0] snap, rd;
        void'($urandom(32'd1234));

        // R1: reset state
        #2 check("R1");
        #2 rst_n = 1'b1;
        #2 check("R1");

        // R6 R7: control decode across all bypass/squelch combinations
        load_word(64'h06_11_22_33_44_55_6677, "R6 R7");
        load_word(64'h02_01_02_03_04_05_0607, "R6 R7");
        load_word(64'h04_80_40_20_10_08_0402, "R6 R7");
        load_word(64'hF0_FF_00_FF_00_FF_00FF, "R6 R7");
        load_word(64'hA9_5A_A5_3C_C3_0F_F00F, "R2");

        // R3 R4 R5: capture then full readout
        cpu_gpr = 32'hD4C3B2A1;
        cpu_pc  = 8'h5E;
        cpu_ir  = 16'h9A3C;
        cpu_pulse();
        step(1'b1, "R3");
        step(1'b0, "R3");
        step(1'b1, "R3");
        snap = model;
        rd = '0;
        for (int i = 0; i < CW; i++) begin
            rd = {rd[CW-2:0], miso};
            step(1'b0, "R5");
        end
        checks++;
        if (rd !== snap || snap[CW-9:0] !== 56'hA1_B2_C3_D4_5E_9A3C) begin
            fails++;
            $display("FAIL R5: got %h expected %h", rd, snap);
        end

        // R8: processor values change with no request
        cpu_gpr = 32'h13572468;
        cpu_pc  = 8'hEE;
        cpu_ir  = 16'hBEEF;
        load_word(64'h3C_01_23_45_67_89_ABCD, "R8");
        for (int i = 0; i < 6; i++) step(1'(i), "R8");

        // R9: asynchronous reset clears state and drops a pending request
        cpu_pulse();
        rst_n = 1'b0;
        #1;
        model = '0;
        cap_cnt = 0;
        check("R9");
        #1 rst_n = 1'b1;
        #2;
        for (int i = 0; i < 5; i++) step(1'b1, "R9");

        // Random bursts
        for (int it = 0; it < 80; it++) begin
            int n;
            cpu_gpr = $urandom;
            cpu_pc  = 8'($urandom);
            cpu_ir  = 16'($urandom);
            if ($urandom % 2 == 0) cpu_pulse();
            n = 3 + ($urandom % 10);
            for (int k = 0; k < n; k++) step(1'($urandom), "R8");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog R1: run hung, got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule